// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the word address for a synchronous burst memory. An address on the input bus is captured on a rising clock edge when a processor-side strobe or a controller-side strobe is high. That captured word is the first beat of a four-beat burst. Each later rising edge with the advance input high moves to the next beat. The low two address bits follow the beat, and the upper bits stay as captured.

A static ordering input selects how the low bits follow the beat. When it is low, they count upward from the start word modulo four. When it is high, they are the start word XOR the beat number. After the fourth beat the sequence wraps to the start word and never carries into the upper bits.

The block reports the current address, the beat number within the burst, and a flag for the final beat. A low level on the reset input clears the state at once. Release of reset is synchronised to the clock inside the block.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst_n` is low, `addr_out` and `beat` read zero. Normal operation resumes on the third rising edge after `rst_n` rises.
- R2: At a rising edge with `strobe_cpu` high, `addr_in` is captured. After that edge `addr_out` equals the captured address and `beat` is 0.
- R3: At a rising edge with `strobe_ctl` high, `addr_in` is captured in the same way as in R2.
- R4: Both strobes high in one cycle act as a single load. An `advance` in a load cycle is ignored, so `beat` reads 0 after that edge.
- R5: At a rising edge with `advance` high and no strobe, `beat` increases by 1 modulo 4. The upper address bits (all but the two lowest) do not change. `last_beat` is high exactly when `beat` is 3.
- R6: With `interleave` low, `addr_out[1:0]` equals (start + `beat`) mod 4, where start is the captured low two bits.
- R7: With `interleave` high, `addr_out[1:0]` equals start XOR `beat`. For example, a start of 1 gives 1, 0, 3, 2.
- R8: An advance on the fourth beat returns `addr_out` to the start address, with `beat` 0.
- R9: At a rising edge with no strobe and no advance, `addr_out` and `beat` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert, synchronised release |
| addr_in | input | ADDR_W | Address bus sampled on a strobe |
| strobe_cpu | input | 1 | Processor-side address strobe, starts a burst |
| strobe_ctl | input | 1 | Controller-side address strobe, starts a burst |
| advance | input | 1 | Steps to the next beat |
| interleave | input | 1 | Static ordering select: 0 linear, 1 XOR-interleaved |
| addr_out | output | ADDR_W | Current word address |
| beat | output | CNT_W | Beat number within the burst |
| last_beat | output | 1 | High on the fourth beat |

## Verification
A load and an advance can fall in the same cycle, and so can the two strobes. The bench provokes both by raising both strobes together with `advance` in one cycle. It judges the result by whether the next address is the start word with beat 0, not a stepped address. A change of ordering mode can also coincide with a load. The sweep changes mode only together with a strobe, then confirms that the first beat is the start word in either mode.

// File: rtl/bas_pkg.sv
package bas_pkg;
  typedef enum logic [1:0] {
    CMD_HOLD = 2'd0,
    CMD_LOAD = 2'd1,
    CMD_STEP = 2'd2
  } cmd_e;
endpackage

// File: rtl/bas_rst_sync.sv
module bas_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/bas_beat_ctr.sv
module bas_beat_ctr
  import bas_pkg::*;
#(
  parameter  int ADDR_W = 16,
  parameter  int CNT_W  = 2,
  localparam int HI_W   = ADDR_W - CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cmd_e              cmd,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [HI_W-1:0]   base_q,
  output logic [CNT_W-1:0]  start_q,
  output logic [CNT_W-1:0]  count_q
);
  logic [HI_W-1:0]  base_d;
  logic [CNT_W-1:0] start_d;
  logic [CNT_W-1:0] count_d;
  logic             en;

  always_comb begin
    base_d  = base_q;
    start_d = start_q;
    count_d = count_q;
    en      = 1'b0;
    unique case (cmd)
      CMD_LOAD: begin
        base_d  = addr_in[ADDR_W-1:CNT_W];
        start_d = addr_in[CNT_W-1:0];
        count_d = '0;
        en      = 1'b1;
      end
      CMD_STEP: begin
        count_d = count_q + CNT_W'(1);
        en      = 1'b1;
      end
      default: en = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      start_q <= '0;
      count_q <= '0;
    end else if (en) begin
      base_q  <= base_d;
      start_q <= start_d;
      count_q <= count_d;
    end
  end
endmodule

// File: rtl/bas_order_map.sv
module bas_order_map #(
  parameter int CNT_W = 2
) (
  input  logic [CNT_W-1:0] start,
  input  logic [CNT_W-1:0] count,
  input  logic             interleave,
  output logic [CNT_W-1:0] low_bits
);
  always_comb begin
    if (interleave) low_bits = start ^ count;
    else            low_bits = start + count;
  end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import bas_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              strobe_cpu,
  input  logic              strobe_ctl,
  input  logic              advance,
  input  logic              interleave,
  output logic [ADDR_W-1:0] addr_out,
  output logic [CNT_W-1:0]  beat,
  output logic              last_beat
);
  localparam int HI_W = ADDR_W - CNT_W;

  logic             rst_sync_n;
  cmd_e             cmd;
  logic [HI_W-1:0]  base_q;
  logic [CNT_W-1:0] start_q;
  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] low_bits;

  bas_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // Either strobe loads. A load outranks advance.
  always_comb begin
    if (strobe_cpu || strobe_ctl) cmd = CMD_LOAD;
    else if (advance)             cmd = CMD_STEP;
    else                          cmd = CMD_HOLD;
  end

  bas_beat_ctr #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_ctr (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .cmd     (cmd),
    .addr_in (addr_in),
    .base_q  (base_q),
    .start_q (start_q),
    .count_q (count_q)
  );

  bas_order_map #(.CNT_W(CNT_W)) u_map (
    .start      (start_q),
    .count      (count_q),
    .interleave (interleave),
    .low_bits   (low_bits)
  );

  assign addr_out  = {base_q, low_bits};
  assign beat      = count_q;
  assign last_beat = &count_q;
endmodule

// File: rtl/bas_checker.sv
module bas_checker #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 2
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic [ADDR_W-1:0] addr_in,
  input logic              strobe_cpu,
  input logic              strobe_ctl,
  input logic              advance,
  input logic              interleave,
  input logic [ADDR_W-1:0] addr_out,
  input logic [CNT_W-1:0]  beat
);
  logic ld;
  assign ld = strobe_cpu || strobe_ctl;

  p_load_capture_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ld |=> (addr_out == $past(addr_in)) && (beat == '0));

  p_adv_ignored_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (strobe_cpu && strobe_ctl && advance) |=> (beat == '0));

  p_step_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!ld && advance) |=> (beat == CNT_W'($past(beat) + CNT_W'(1))));

  p_no_carry_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !ld |=> $stable(addr_out[ADDR_W-1:CNT_W]));

  p_linear_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!ld && advance && !interleave) |=>
      (interleave || (addr_out[CNT_W-1:0] == CNT_W'($past(addr_out[CNT_W-1:0]) + CNT_W'(1)))));

  p_interleave_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!ld && advance && interleave) |=>
      (!interleave || ((addr_out[CNT_W-1:0] ^ beat) == $past(addr_out[CNT_W-1:0] ^ beat))));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!ld && !advance) |=>
      (!$stable(interleave) || ($stable(addr_out) && $stable(beat))));
endmodule

bind burst_addr_seq bas_checker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .addr_in    (addr_in),
  .strobe_cpu (strobe_cpu),
  .strobe_ctl (strobe_ctl),
  .advance    (advance),
  .interleave (interleave),
  .addr_out   (addr_out),
  .beat       (beat)
);

// File: tb/burst_addr_seq_bench.sv
`timescale 1ns/1ps
module burst_addr_seq_bench;
  localparam int AW = 16;
  localparam int CW = 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] addr_in;
  logic          strobe_cpu, strobe_ctl, advance, interleave;
  logic [AW-1:0] addr_out;
  logic [CW-1:0] beat;
  logic          last_beat;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  burst_addr_seq #(.ADDR_W(AW), .CNT_W(CW)) u_burst_addr_seq (
    .clk(clk), .rst_n(rst_n), .addr_in(addr_in), .strobe_cpu(strobe_cpu),
    .strobe_ctl(strobe_ctl), .advance(advance), .interleave(interleave),
    .addr_out(addr_out), .beat(beat), .last_beat(last_beat)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h expected=%h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [CW-1:0] exp_low(logic m, logic [CW-1:0] s, logic [CW-1:0] n);
    return m ? (s ^ n) : CW'(s + n);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [AW-CW-1:0] hi;
    logic [CW-1:0]    n;
    logic [CW-1:0]    s;
    logic [AW-1:0]    cur;

    rst_n = 1'b1; addr_in = '0; strobe_cpu = 0; strobe_ctl = 0; advance = 0; interleave = 0;
    #1 rst_n = 1'b0;
    repeat (3) tick();
    chk("R1 reset addr", 32'(addr_out), 32'h0);
    chk("R1 reset beat", 32'(beat), 32'h0);
    rst_n = 1'b1;
    repeat (3) tick();

    for (int m = 0; m < 2; m++)
      for (int st = 0; st < 4; st++)
        for (int kind = 0; kind < 3; kind++)
          for (int hv = 0; hv < 2; hv++) begin
            hi = (hv == 0) ? {(AW-CW){1'b1}} : (AW-CW)'(16'h1357 * (st + 4*kind + 1));
            s  = CW'(st);
            addr_in    = {hi, s};
            interleave = m[0];
            strobe_cpu = (kind != 1);
            strobe_ctl = (kind != 0);
            advance    = (kind == 2);
            tick();
            strobe_cpu = 0; strobe_ctl = 0; advance = 0;
            addr_in    = ~addr_in;
            n = '0;
            case (kind)
              0: chk("R2 load addr", 32'(addr_out), 32'({hi, s}));
              1: chk("R3 load addr", 32'(addr_out), 32'({hi, s}));
              default: begin
                chk("R4 dual load addr", 32'(addr_out), 32'({hi, s}));
                chk("R4 advance ignored beat", 32'(beat), 32'h0);
              end
            endcase
            // advance pattern: A, idle, A, A, A, A
            for (int k = 0; k < 6; k++) begin
              cur = addr_out;
              advance = (k != 1);
              tick();
              if (k == 1) begin
                advance = 0;
                chk("R9 hold addr", 32'(addr_out), 32'(cur));
                chk("R9 hold beat", 32'(beat), 32'(n));
              end else begin
                advance = 0;
                n = n + CW'(1);
                chk("R5 beat step", 32'(beat), 32'(n));
                chk("R5 upper fixed", 32'(addr_out[AW-1:CW]), 32'(hi));
                chk("R5 last flag", 32'(last_beat), 32'(n == 2'd3));
                if (n == '0)
                  chk("R8 wrap to start", 32'(addr_out), 32'({hi, s}));
                else if (m == 1)
                  chk("R7 interleaved low", 32'(addr_out[CW-1:0]), 32'(exp_low(1'b1, s, n)));
                else
                  chk("R6 linear low", 32'(addr_out[CW-1:0]), 32'(exp_low(1'b0, s, n)));
              end
            end
          end

    // reset in mid burst
    addr_in = 16'hBEEF; strobe_cpu = 1; tick(); strobe_cpu = 0;
    advance = 1; tick(); advance = 0;
    rst_n = 1'b0;
    tick();
    chk("R1 mid reset addr", 32'(addr_out), 32'h0);
    chk("R1 mid reset beat", 32'(beat), 32'h0);
    rst_n = 1'b1;
    repeat (3) tick();

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule